// File: doc/BRIEF.md
# Peripheral Clock Mask Controller

This controller keeps one enable bit for every peripheral bus clock. It drives each bit straight out as a registered clock-enable signal, so that gating cells elsewhere can stop the clock. The enables sit in four 32-bit mask words. The word at word offset 0 holds the system-bus (AHB) side enables. Offsets 1, 2 and 3 hold the enables for the peripheral-bus (APB) bridges A, B and C. A peripheral that is reached from two domains owns one bit on each side. Software reads and writes the words through an APB-style slave port. That port has no wait states: `pready` is always 1, so the block never applies back-pressure and a requester may start an access in any cycle.

A second, pass-through APB path models what gating means for an access. Every access aimed at a peripheral is tagged with a peripheral index. When that peripheral's APB enable is cleared, the access is not forwarded, it completes at once with an error, and it returns zero data.

The controller is reached through its own APB clock and through the bridge that carries its accesses. If software clears either of those two enables, the mask words lock. Every later access to them fails until a synchronous reset. Build-time parameters set which bit positions exist and which peripherals are absent. An absent peripheral's enable is fixed at 0.

Top module: `clk_mask_ctrl`

## Requirements
- R1: One cycle after `rst_n` has been low at a rising edge, every implemented and present enable bit reads 1, and every reserved or absent bit reads 0.
- R2: A write completes when `psel`, `penable` and `pwrite` are all high at a rising edge. It stores `pwdata` into the word chosen by `paddr[3:2]` (0 = AHB, 1 = bridge A, 2 = bridge B, 3 = bridge C). The enable outputs show the new value from that edge on. A read returns the current word on `prdata` during the access phase.
- R3: Bit positions that `IMPL_MASK` leaves unset always read 0, on `prdata` and on the enable outputs, and writes do not change them.
- R4: A peripheral marked in `ABSENT_MASK` has an enable that stays 0 from reset onward, whatever is written to it.
- R5: The mask words lock once the controller's own APB enable (flat bit `SELF_EN_POS`, default bridge A bit 2) or the AHB enable of its bridge (AHB bit `BRIDGE_EN_POS`, default bit 0) reads 0. While locked, every access phase returns `pslverr` = 1 and `prdata` = 0, and writes change nothing.
- R6: A reset releases the lock and restores every default enable.
- R7: `pa_pidx[6:5]` selects the bridge (0 = A, 1 = B, 2 = C) and `pa_pidx[4:0]` selects the bit. Take a peripheral access whose enable is 0, or whose bridge field is 3. For that access `pa_fwd_sel` stays 0, `pa_pready` is 1, `pa_prdata` is 0, and `pa_pslverr` is 1 during the access phase.
- R8: While the addressed peripheral's APB enable is 1, the select, ready, read data and error are passed through unchanged. Setting a cleared bit back to 1 restores this at once.
- R9: The mask port always returns `pready` = 1, and it returns `pslverr` = 0 for any access made while unlocked.
- R10: A write to one mask word leaves the other three words unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| psel | input | 1 | Mask port select |
| penable | input | 1 | Mask port access phase |
| pwrite | input | 1 | Mask port write strobe |
| paddr | input | 4 | Byte address; bits 3:2 pick the word |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Error while locked |
| ahb_clk_en | output | 32 | AHB-side clock enables |
| apb_clk_en | output | 96 | Bridge A, B, C enables, A in the low 32 bits |
| pa_psel | input | 1 | Peripheral access select |
| pa_penable | input | 1 | Peripheral access phase |
| pa_pidx | input | 7 | Target peripheral index |
| pa_pready_in | input | 1 | Ready from the peripheral |
| pa_pslverr_in | input | 1 | Error from the peripheral |
| pa_prdata_in | input | 32 | Read data from the peripheral |
| pa_fwd_sel | output | 1 | Select forwarded to the peripheral |
| pa_pready | output | 1 | Ready to the requester |
| pa_pslverr | output | 1 | Error to the requester |
| pa_prdata | output | 32 | Read data to the requester |

## Verification
The bench keeps the default implemented-bit layout and the default lock positions: bridge A bit 2 for the controller itself and AHB bit 0 for its bridge. It overrides `ABSENT_MASK` to mark bridge C bit 4 as absent. That override makes the fixed-zero enable reachable in three ways: in the reset values, after an all-ones write, and as a refused peripheral access. The default lock positions let both lock triggers be set off from ordinary writes and then released by reset.

// File: rtl/clk_mask_pkg.sv
package clk_mask_pkg;
  localparam int REG_W   = 32;
  localparam int NUM_REG = 4;
  localparam int NUM_BR  = NUM_REG - 1;
  localparam int IDX_W   = $clog2(NUM_REG);

  typedef enum logic [IDX_W-1:0] {
    WORD_AHB = 2'd0,
    WORD_BRA = 2'd1,
    WORD_BRB = 2'd2,
    WORD_BRC = 2'd3
  } word_sel_e;

  typedef logic [NUM_REG-1:0][REG_W-1:0] mask_bank_t;
endpackage

// File: rtl/clk_mask_regs.sv
module clk_mask_regs
  import clk_mask_pkg::*;
#(
  parameter logic [NUM_REG*REG_W-1:0] IMPL_MASK   = '1,
  parameter logic [NUM_REG*REG_W-1:0] ABSENT_MASK = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [REG_W-1:0] wr_data,
  output mask_bank_t       mask_q
);
  for (genvar g = 0; g < NUM_REG; g++) begin : g_word
    localparam logic [REG_W-1:0] KEEP =
      IMPL_MASK[g*REG_W +: REG_W] & ~ABSENT_MASK[g*REG_W +: REG_W];
    logic hit;
    assign hit = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n)   mask_q[g] <= KEEP;
      else if (hit) mask_q[g] <= wr_data & KEEP;
    end
  end
endmodule

// File: rtl/clk_mask_lock.sv
module clk_mask_lock
  import clk_mask_pkg::*;
#(
  parameter int SELF_EN_POS   = 34,
  parameter int BRIDGE_EN_POS = 0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  mask_bank_t mask_q,
  output logic       locked
);
  logic [NUM_REG*REG_W-1:0] flat;
  logic trig, sticky_q;

  assign flat   = mask_q;
  assign trig   = !flat[SELF_EN_POS] || !flat[BRIDGE_EN_POS];
  assign locked = sticky_q || trig;

  always_ff @(posedge clk) begin
    if (!rst_n)    sticky_q <= 1'b0;
    else if (trig) sticky_q <= 1'b1;
  end
endmodule

// File: rtl/clk_mask_gate.sv
module clk_mask_gate
  import clk_mask_pkg::*;
#(
  parameter int PIDX_W = 7
) (
  input  logic [NUM_BR*REG_W-1:0] apb_en,
  input  logic                    pa_psel,
  input  logic                    pa_penable,
  input  logic [PIDX_W-1:0]       pa_pidx,
  input  logic                    pa_pready_in,
  input  logic                    pa_pslverr_in,
  input  logic [REG_W-1:0]        pa_prdata_in,
  output logic                    pa_fwd_sel,
  output logic                    pa_pready,
  output logic                    pa_pslverr,
  output logic [REG_W-1:0]        pa_prdata
);
  localparam int SPAN = 1 << PIDX_W;
  logic [SPAN-1:0] en_ext;
  logic            open_q;

  always_comb begin
    en_ext = '0;
    en_ext[NUM_BR*REG_W-1:0] = apb_en;
  end

  assign open_q     = en_ext[pa_pidx];
  assign pa_fwd_sel = pa_psel && open_q;
  assign pa_pready  = open_q ? pa_pready_in : 1'b1;
  assign pa_pslverr = open_q ? pa_pslverr_in : (pa_psel && pa_penable);
  assign pa_prdata  = open_q ? pa_prdata_in : '0;
endmodule

// File: rtl/clk_mask_ctrl.sv
module clk_mask_ctrl
  import clk_mask_pkg::*;
#(
  parameter logic [NUM_REG*REG_W-1:0] IMPL_MASK =
    {32'h0001_FFFF, 32'h0000_003F, 32'h0000_3FFF, 32'h0000_01FF},
  parameter logic [NUM_REG*REG_W-1:0] ABSENT_MASK = '0,
  parameter int SELF_EN_POS   = 34,
  parameter int BRIDGE_EN_POS = 0,
  parameter int ADDR_W        = 4,
  parameter int PIDX_W        = 7
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    psel,
  input  logic                    penable,
  input  logic                    pwrite,
  input  logic [ADDR_W-1:0]       paddr,
  input  logic [REG_W-1:0]        pwdata,
  output logic [REG_W-1:0]        prdata,
  output logic                    pready,
  output logic                    pslverr,
  output logic [REG_W-1:0]        ahb_clk_en,
  output logic [NUM_BR*REG_W-1:0] apb_clk_en,
  input  logic                    pa_psel,
  input  logic                    pa_penable,
  input  logic [PIDX_W-1:0]       pa_pidx,
  input  logic                    pa_pready_in,
  input  logic                    pa_pslverr_in,
  input  logic [REG_W-1:0]        pa_prdata_in,
  output logic                    pa_fwd_sel,
  output logic                    pa_pready,
  output logic                    pa_pslverr,
  output logic [REG_W-1:0]        pa_prdata
);
  mask_bank_t       mask_q;
  logic             locked, access, do_wr;
  logic [IDX_W-1:0] word_idx;

  assign word_idx = paddr[IDX_W+1:2];
  assign access   = psel && penable;
  assign do_wr    = access && pwrite && !locked;

  clk_mask_regs #(.IMPL_MASK(IMPL_MASK), .ABSENT_MASK(ABSENT_MASK)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(do_wr), .wr_idx(word_idx),
    .wr_data(pwdata), .mask_q(mask_q)
  );

  clk_mask_lock #(.SELF_EN_POS(SELF_EN_POS), .BRIDGE_EN_POS(BRIDGE_EN_POS)) u_lock (
    .clk(clk), .rst_n(rst_n), .mask_q(mask_q), .locked(locked)
  );

  assign ahb_clk_en = mask_q[WORD_AHB];
  for (genvar b = 0; b < NUM_BR; b++) begin : g_br
    assign apb_clk_en[b*REG_W +: REG_W] = mask_q[b+1];
  end

  assign pready  = 1'b1;
  assign pslverr = access && locked;
  assign prdata  = locked ? '0 : mask_q[word_idx];

  clk_mask_gate #(.PIDX_W(PIDX_W)) u_gate (
    .apb_en(apb_clk_en), .pa_psel(pa_psel), .pa_penable(pa_penable),
    .pa_pidx(pa_pidx), .pa_pready_in(pa_pready_in),
    .pa_pslverr_in(pa_pslverr_in), .pa_prdata_in(pa_prdata_in),
    .pa_fwd_sel(pa_fwd_sel), .pa_pready(pa_pready),
    .pa_pslverr(pa_pslverr), .pa_prdata(pa_prdata)
  );
endmodule

// File: rtl/clk_mask_ctrl_chk.sv
module clk_mask_ctrl_chk
  import clk_mask_pkg::*;
#(
  parameter logic [NUM_REG*REG_W-1:0] IMPL_MASK   = '1,
  parameter logic [NUM_REG*REG_W-1:0] ABSENT_MASK = '0,
  parameter int SELF_EN_POS   = 34,
  parameter int BRIDGE_EN_POS = 0,
  parameter int PIDX_W        = 7
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    psel,
  input logic                    penable,
  input logic [REG_W-1:0]        prdata,
  input logic                    pready,
  input logic                    pslverr,
  input logic [REG_W-1:0]        ahb_clk_en,
  input logic [NUM_BR*REG_W-1:0] apb_clk_en,
  input logic                    pa_psel,
  input logic [PIDX_W-1:0]       pa_pidx,
  input logic                    pa_fwd_sel
);
  localparam logic [NUM_REG*REG_W-1:0] DEFAULTS = IMPL_MASK & ~ABSENT_MASK;
  logic [NUM_REG*REG_W-1:0] all_en;
  logic lock_seen, tgt_on;
  logic [(1<<PIDX_W)-1:0] ext;

  assign all_en    = {apb_clk_en, ahb_clk_en};
  assign lock_seen = !all_en[SELF_EN_POS] || !all_en[BRIDGE_EN_POS];
  always_comb begin
    ext = '0;
    ext[NUM_BR*REG_W-1:0] = apb_clk_en;
  end
  assign tgt_on = ext[pa_pidx];

  assert_reset_defaults_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> all_en == DEFAULTS);
  assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (all_en & ~IMPL_MASK) == '0);
  assert_absent_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (all_en & ABSENT_MASK) == '0);
  assert_frozen_when_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lock_seen |=> $stable(all_en));
  assert_locked_error_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && penable && lock_seen) |-> (pslverr && prdata == '0));
  assert_gated_no_forward_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pa_psel && !tgt_on) |-> !pa_fwd_sel);
  assert_no_wait_R9: assert property (@(posedge clk) disable iff (!rst_n) pready);
endmodule

bind clk_mask_ctrl clk_mask_ctrl_chk #(
  .IMPL_MASK(IMPL_MASK), .ABSENT_MASK(ABSENT_MASK),
  .SELF_EN_POS(SELF_EN_POS), .BRIDGE_EN_POS(BRIDGE_EN_POS), .PIDX_W(PIDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .prdata(prdata),
  .pready(pready), .pslverr(pslverr), .ahb_clk_en(ahb_clk_en),
  .apb_clk_en(apb_clk_en), .pa_psel(pa_psel), .pa_pidx(pa_pidx),
  .pa_fwd_sel(pa_fwd_sel)
);

// File: tb/tb_clk_mask_ctrl.sv
module tb_clk_mask_ctrl;
  localparam logic [127:0] IMPL   = {32'h0001_FFFF, 32'h0000_003F, 32'h0000_3FFF, 32'h0000_01FF};
  localparam logic [127:0] ABSENT = 128'h1 << 100;

  logic clk = 0, rst_n = 0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [3:0] paddr = 0;
  logic [31:0] pwdata = 0, prdata;
  logic pready, pslverr;
  logic [31:0] ahb_clk_en;
  logic [95:0] apb_clk_en;
  logic pa_psel = 0, pa_penable = 0, pa_pready_in = 1, pa_pslverr_in = 0;
  logic [6:0] pa_pidx = 0;
  logic [31:0] pa_prdata_in = 32'hDEAD_BEEF, pa_prdata;
  logic pa_fwd_sel, pa_pready, pa_pslverr;

  int checks = 0, fails = 0;
  logic [31:0] m [4];
  logic m_sticky;
  logic [31:0] rd;
  logic er;

  always #10 clk = ~clk;

  clk_mask_ctrl #(.ABSENT_MASK(ABSENT)) dut (.*);

  function automatic logic m_locked();
    return m_sticky || !m[1][2] || !m[0][0];
  endfunction

  // behavioural reference, updated on the same edge as the design
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) m[i] <= IMPL[i*32 +: 32] & ~ABSENT[i*32 +: 32];
      m_sticky <= 1'b0;
    end else begin
      if (m_locked()) m_sticky <= 1'b1;
      if (psel && penable && pwrite && !m_locked())
        m[paddr[3:2]] <= pwdata & IMPL[paddr[3:2]*32 +: 32] & ~ABSENT[paddr[3:2]*32 +: 32];
    end
  end

  task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R2: enable outputs compared to the model on every clock
  always @(negedge clk) if (rst_n && $time > 40) begin
    check("R2 ahb", ahb_clk_en, m[0]);
    check("R2 apb", apb_clk_en, {m[3], m[2], m[1]});
  end

  task automatic apb(input logic wr, input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1; penable = 0; pwrite = wr; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1;
    #1 rd = prdata; er = pslverr;
    check("R9 pready", pready, 1);
    @(negedge clk);
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  task automatic pa_probe(input logic [6:0] idx);
    @(negedge clk);
    pa_psel = 1; pa_penable = 1; pa_pidx = idx;
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    // R1
    check("R1 ahb reset", ahb_clk_en, 32'h1FF);
    check("R1 apb reset", apb_clk_en, {32'h0001_FFEF, 32'h3F, 32'h3FFF});
    // R2 / R10 / R9
    apb(1, 4'h0, 32'h0000_0155);
    apb(0, 4'h0, 0);
    check("R2 readback", rd, 32'h155);
    check("R9 no error", er, 0);
    check("R10 others kept", apb_clk_en, {32'h0001_FFEF, 32'h3F, 32'h3FFF});
    apb(1, 4'h0, 32'h1FF);
    // R3
    apb(1, 4'h8, 32'hFFFF_FFFF);
    apb(0, 4'h8, 0);
    check("R3 reserved", rd, 32'h3F);
    // R4
    apb(1, 4'hC, 32'hFFFF_FFFF);
    apb(0, 4'hC, 0);
    check("R4 absent", rd, 32'h0001_FFEF);
    pa_probe(7'd68);
    check("R4 absent access err", {pa_fwd_sel, pa_pslverr, pa_prdata}, {1'b0, 1'b1, 32'h0});
    pa_psel = 0; pa_penable = 0;
    // R7: clear bridge A bit 7
    apb(1, 4'h4, 32'h3FFF & ~32'h80);
    pa_probe(7'd7);
    check("R7 gated", {pa_fwd_sel, pa_pready, pa_pslverr, pa_prdata}, {1'b0, 1'b1, 1'b1, 32'h0});
    pa_probe(7'd96);
    check("R7 bridge 3", {pa_fwd_sel, pa_pslverr}, {1'b0, 1'b1});
    pa_psel = 0; pa_penable = 0;
    // R8
    apb(1, 4'h4, 32'h3FFF);
    pa_pslverr_in = 0; pa_pready_in = 0;
    pa_probe(7'd7);
    check("R8 restored", {pa_fwd_sel, pa_pready, pa_pslverr, pa_prdata}, {1'b1, 1'b0, 1'b0, 32'hDEAD_BEEF});
    pa_psel = 0; pa_penable = 0; pa_pready_in = 1;
    // R5: self lock through bridge A bit 2
    apb(1, 4'h4, 32'h3FFB);
    apb(1, 4'h0, 32'h0);
    check("R5 write ignored", ahb_clk_en, 32'h1FF);
    apb(1, 4'h4, 32'h3FFF);
    check("R5 lock sticky", er, 1);
    check("R5 still cleared", apb_clk_en[2], 0);
    apb(0, 4'h0, 0);
    check("R5 read blocked", {er, rd}, {1'b1, 32'h0});
    // R6
    do_reset();
    apb(1, 4'h8, 32'h5);
    apb(0, 4'h8, 0);
    check("R6 unlocked", {er, rd}, {1'b0, 32'h5});
    // R5: lock through AHB bridge bit 0
    apb(1, 4'h0, 32'h1FE);
    apb(1, 4'h0, 32'h1FF);
    check("R5 bridge lock", {er, ahb_clk_en}, {1'b1, 32'h1FE});
    do_reset();
    @(negedge clk);
    check("R6 defaults", ahb_clk_en, 32'h1FF);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule